// File: doc/BRIEF.md
# Complementary PWM output stage

This block turns the reference waveform of one timer channel into final pin drive. On a paired channel it drives a main output and a complementary output. When both outputs of the pair are enabled, a dead-time generator delays the active edge of each output so that the two are never active together. When only one output is enabled, that output follows the reference with no dead time. Each output has its own enable bit and its own polarity bit. A single-output variant, chosen by a parameter, drives the main output only.

An output-enable gate controls both pins. While the master output enable is high the channel is in run mode: an enabled output drives its level, and a disabled output either drives its inactive level or is released, according to the run off-state select. While the master output enable is low the channel is idle: each output either drives its programmed idle level or is released, according to the idle off-state select.

The dead-time generator is a four-state machine:
- `DT_LOW`: reference low and settled; the complementary output is active.
- `DT_RISE`: the reference has risen and the dead time is counting down.
- `DT_HIGH`: reference high and settled; the main output is active.
- `DT_FALL`: the reference has fallen and the dead time is counting down.

It has these transitions:
- LOW→RISE, or LOW→HIGH directly when the dead time is 0, when the reference is sampled high.
- RISE→HIGH when the count expires.
- RISE→FALL when the reference drops before the count expires.
- HIGH→FALL, or HIGH→LOW directly when the dead time is 0, when the reference is sampled low.
- FALL→LOW when the count expires.
- FALL→RISE when the reference returns high before the count expires.

Top module: `pwm_out_stage`

## Requirements
- R1: While reset is held and for as long as `master_en`=0 and `off_idle`=0, all four outputs are 0. After reset the dead-time generator is in `DT_LOW`.
- R2: When both outputs are enabled, the main output becomes active at edge k+D. Here D is the value of `dead_time` (0 to 255, linear in clock ticks), and k is the edge at which `ref_i` is first sampled high after it has been low for at least D+1 edges.
- R3: When both outputs are enabled, the complementary output becomes active at edge k+D, where k is the edge at which `ref_i` is first sampled low.
- R4: When both outputs are enabled, the main and complementary outputs are never active in the same cycle.
- R5: Suppose both outputs are enabled and `ref_i` is sampled high for P consecutive edges, with P ≤ D. Then the main output stays inactive for that whole pulse.
- R6: When only `main_en`=1, the main output's active state equals `ref_i` as sampled at the previous edge. The complementary output's active state is 0.
- R7: When only `comp_en`=1, the complementary output's active state equals the inverse of `ref_i` as sampled at the previous edge. The main output's active state is 0.
- R8: When an output is enabled, polarity bit 0 drives its active state as 1. Polarity bit 1 drives the inverse.
- R9: With `master_en`=1, each output enable equals that output's enable bit OR `off_run`. A disabled output whose output enable is 1 drives its polarity bit, which is its inactive level. An output whose output enable is 0 drives 0.
- R10: With `master_en`=0 and `off_idle`=1, both output enables are 1 and each pin drives its idle bit (`idle_main`, `idle_comp`), whatever `ref_i` is.
- R11: With `master_en`=0 and `off_idle`=0, both output enables and both pins are 0.
- R12: With `HAS_COMP`=0, `comp_o` and `comp_oe` are always 0. The main output follows R6 and R8 to R11 using `main_en` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference waveform from the compare stage |
| dead_time | input | DT_W | Dead time in clock ticks |
| main_en | input | 1 | Main output enable bit |
| comp_en | input | 1 | Complementary output enable bit |
| main_pol | input | 1 | Main polarity (1 = inverted) |
| comp_pol | input | 1 | Complementary polarity (1 = inverted) |
| idle_main | input | 1 | Main pin level in idle off-state |
| idle_comp | input | 1 | Complementary pin level in idle off-state |
| master_en | input | 1 | Master output enable (1 = run) |
| off_run | input | 1 | Run off-state select |
| off_idle | input | 1 | Idle off-state select |
| main_o | output | 1 | Main pin level |
| main_oe | output | 1 | Main pin output enable |
| comp_o | output | 1 | Complementary pin level |
| comp_oe | output | 1 | Complementary pin output enable |

## Verification
The bench sweeps dead times 0 to 6 against every pulse width and gap up to D+2, including pulses exactly equal to and one shorter than the dead time. A generator that counted one tick too few or too many would move the output edges by a cycle. One that ignored a short pulse's early fall would let the main output glitch active, or would fail to restart the complementary delay. A second sweep covers every combination of enables, polarities, idle bits and the three gating selects. This catches a run/idle mix-up, an idle level that leaks the reference, or a disabled output that is released instead of being held at its inactive level. A single-output instance is checked alongside to confirm that its complementary pin never moves.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;

    typedef enum logic [1:0] {
        DT_LOW  = 2'd0,
        DT_RISE = 2'd1,
        DT_HIGH = 2'd2,
        DT_FALL = 2'd3
    } dt_state_e;

endpackage

// File: rtl/pwm_dt_gen.sv
module pwm_dt_gen
    import pwm_out_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead_time,
    output logic            ref_q,
    output logic            dt_main,
    output logic            dt_comp
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    dt_state_e       state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            dt_zero;

    assign dt_zero = (dead_time == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DT_LOW;
            cnt_q   <= '0;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ref_q   <= ref_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DT_LOW: begin
                if (ref_i) begin
                    state_d = dt_zero ? DT_HIGH : DT_RISE;
                    cnt_d   = dead_time;
                end
            end
            DT_RISE: begin
                if (!ref_i) begin
                    state_d = dt_zero ? DT_LOW : DT_FALL;
                    cnt_d   = dead_time;
                end else if (cnt_q <= ONE) begin
                    state_d = DT_HIGH;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            DT_HIGH: begin
                if (!ref_i) begin
                    state_d = dt_zero ? DT_LOW : DT_FALL;
                    cnt_d   = dead_time;
                end
            end
            DT_FALL: begin
                if (ref_i) begin
                    state_d = dt_zero ? DT_HIGH : DT_RISE;
                    cnt_d   = dead_time;
                end else if (cnt_q <= ONE) begin
                    state_d = DT_LOW;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        dt_main = (state_q == DT_HIGH);
        dt_comp = (state_q == DT_LOW);
    end

endmodule

// File: rtl/pwm_path_sel.sv
module pwm_path_sel #(
    parameter bit HAS_COMP = 1'b1
) (
    input  logic main_en,
    input  logic comp_en,
    input  logic ref_q,
    input  logic dt_main,
    input  logic dt_comp,
    output logic main_sel,
    output logic comp_sel
);

    generate
        if (HAS_COMP) begin : g_pair
            always_comb begin
                unique case ({comp_en, main_en})
                    2'b11: begin main_sel = dt_main; comp_sel = dt_comp; end
                    2'b01: begin main_sel = ref_q;   comp_sel = 1'b0;    end
                    2'b10: begin main_sel = 1'b0;    comp_sel = ~ref_q;  end
                    default: begin main_sel = 1'b0;  comp_sel = 1'b0;    end
                endcase
            end
        end else begin : g_single
            assign main_sel = main_en & ref_q;
            assign comp_sel = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pwm_oe_gate.sv
module pwm_oe_gate (
    input  logic en,
    input  logic pol,
    input  logic idle_lvl,
    input  logic sel,
    input  logic master_en,
    input  logic off_run,
    input  logic off_idle,
    output logic pin,
    output logic oe
);

    always_comb begin
        if (master_en) begin
            oe  = en | off_run;
            pin = (en | off_run) & (sel ^ pol);
        end else begin
            oe  = off_idle;
            pin = off_idle & idle_lvl;
        end
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int DT_W     = 8,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead_time,
    input  logic            main_en,
    input  logic            comp_en,
    input  logic            main_pol,
    input  logic            comp_pol,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            master_en,
    input  logic            off_run,
    input  logic            off_idle,
    output logic            main_o,
    output logic            main_oe,
    output logic            comp_o,
    output logic            comp_oe
);

    localparam int N_OUT = HAS_COMP ? 2 : 1;

    logic ref_q, dt_main, dt_comp, main_sel, comp_sel;
    logic [N_OUT-1:0] en_v, pol_v, idle_v, sel_v, pin_v, oe_v;

    pwm_dt_gen #(.DT_W(DT_W)) u_dt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_i),
        .dead_time (dead_time),
        .ref_q     (ref_q),
        .dt_main   (dt_main),
        .dt_comp   (dt_comp)
    );

    pwm_path_sel #(.HAS_COMP(HAS_COMP)) u_sel (
        .main_en  (main_en),
        .comp_en  (comp_en),
        .ref_q    (ref_q),
        .dt_main  (dt_main),
        .dt_comp  (dt_comp),
        .main_sel (main_sel),
        .comp_sel (comp_sel)
    );

    generate
        if (HAS_COMP) begin : g_pair
            assign en_v   = {comp_en, main_en};
            assign pol_v  = {comp_pol, main_pol};
            assign idle_v = {idle_comp, idle_main};
            assign sel_v  = {comp_sel, main_sel};
            assign comp_o  = pin_v[N_OUT-1];
            assign comp_oe = oe_v[N_OUT-1];
        end else begin : g_single
            assign en_v   = main_en;
            assign pol_v  = main_pol;
            assign idle_v = idle_main;
            assign sel_v  = main_sel;
            assign comp_o  = 1'b0;
            assign comp_oe = 1'b0;
        end

        for (genvar i = 0; i < N_OUT; i++) begin : g_gate
            pwm_oe_gate u_gate (
                .en        (en_v[i]),
                .pol       (pol_v[i]),
                .idle_lvl  (idle_v[i]),
                .sel       (sel_v[i]),
                .master_en (master_en),
                .off_run   (off_run),
                .off_idle  (off_idle),
                .pin       (pin_v[i]),
                .oe        (oe_v[i])
            );
        end
    endgenerate

    assign main_o  = pin_v[0];
    assign main_oe = oe_v[0];

endmodule

// File: rtl/pwm_out_stage_chk.sv
module pwm_out_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_i,
    input logic main_en,
    input logic comp_en,
    input logic main_pol,
    input logic comp_pol,
    input logic idle_main,
    input logic master_en,
    input logic off_run,
    input logic off_idle,
    input logic main_o,
    input logic main_oe,
    input logic comp_o,
    input logic comp_oe,
    input logic dt_main,
    input logic dt_comp
);

    AST_MAIN_RISE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_main) |-> $past(ref_i)); // R2

    AST_COMP_RISE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_comp) |-> !$past(ref_i)); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && main_en && comp_en && comp_oe)
            |-> !((main_o ^ main_pol) && (comp_o ^ comp_pol))); // R4

    AST_MAIN_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && main_en && !comp_en && $past(rst_n))
            |-> (main_o == ($past(ref_i) ^ main_pol))); // R6

    AST_RUN_OE: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |-> (main_oe == (main_en | off_run))); // R9

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && off_idle) |-> (main_oe && (main_o == idle_main))); // R10

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !off_idle) |-> !(main_oe || comp_oe || main_o || comp_o)); // R11

endmodule

bind pwm_out_stage pwm_out_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_i     (ref_i),
    .main_en   (main_en),
    .comp_en   (comp_en),
    .main_pol  (main_pol),
    .comp_pol  (comp_pol),
    .idle_main (idle_main),
    .master_en (master_en),
    .off_run   (off_run),
    .off_idle  (off_idle),
    .main_o    (main_o),
    .main_oe   (main_oe),
    .comp_o    (comp_o),
    .comp_oe   (comp_oe),
    .dt_main   (dt_main),
    .dt_comp   (dt_comp)
);

// File: tb/tb_pwm_out_stage.sv
module tb_pwm_out_stage;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0;
    logic [7:0] dead_time = 8'd0;
    logic main_en = 0, comp_en = 0, main_pol = 0, comp_pol = 0;
    logic idle_main = 0, idle_comp = 0;
    logic master_en = 0, off_run = 0, off_idle = 0;
    logic main_o, main_oe, comp_o, comp_oe;
    logic s_main_o, s_main_oe, s_comp_o, s_comp_oe;

    int n_vec = 0;
    int n_bad = 0;
    int hi_run = 0;
    int lo_run = 1000;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_out_stage #(.DT_W(8), .HAS_COMP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_time(dead_time),
        .main_en(main_en), .comp_en(comp_en), .main_pol(main_pol), .comp_pol(comp_pol),
        .idle_main(idle_main), .idle_comp(idle_comp), .master_en(master_en),
        .off_run(off_run), .off_idle(off_idle),
        .main_o(main_o), .main_oe(main_oe), .comp_o(comp_o), .comp_oe(comp_oe)
    );

    pwm_out_stage #(.DT_W(8), .HAS_COMP(1'b0)) dut4 (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_time(dead_time),
        .main_en(main_en), .comp_en(comp_en), .main_pol(main_pol), .comp_pol(comp_pol),
        .idle_main(idle_main), .idle_comp(idle_comp), .master_en(master_en),
        .off_run(off_run), .off_idle(off_idle),
        .main_o(s_main_o), .main_oe(s_main_oe), .comp_o(s_comp_o), .comp_oe(s_comp_oe)
    );

    function automatic logic [1:0] gate(input logic en, input logic pol, input logic idl,
                                        input logic sel);
        if (master_en) return (en | off_run) ? {1'b1, sel ^ pol} : 2'b00;
        return off_idle ? {1'b1, idl} : 2'b00;
    endfunction

    function automatic string tag_for(input logic en, input logic pol);
        string t;
        if (!master_en) t = off_idle ? "R10" : "R11";
        else if (!en) t = "R9";
        else if (main_en && comp_en) t = "R2 R3 R5";
        else t = main_en ? "R6" : "R7";
        if (pol && master_en && en) t = {t, " R8"};
        return t;
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b (dt=%0d)", tag, $time, got, exp,
                     dead_time);
        end
    endtask

    task automatic check_all();
        logic ms, cs;
        logic [1:0] em, ec, e4;
        int d;
        d = int'(dead_time);
        if (main_en && comp_en) begin
            ms = (hi_run >= d + 1);
            cs = (lo_run >= d + 1);
        end else begin
            ms = main_en && (hi_run > 0);
            cs = comp_en && (lo_run > 0);
        end
        em = gate(main_en, main_pol, idle_main, ms);
        ec = gate(comp_en, comp_pol, idle_comp, cs);
        chk({tag_for(main_en, main_pol), " main"}, {main_oe, main_o}, {2'b00, em});
        chk({tag_for(comp_en, comp_pol), " comp"}, {comp_oe, comp_o}, {2'b00, ec});
        e4 = gate(main_en, main_pol, idle_main, main_en && (hi_run > 0));
        chk("R12 single", {s_comp_oe, s_comp_o, s_main_oe, s_main_o}, {2'b00, e4});
    endtask

    task automatic cyc(input logic r);
        @(negedge clk);
        ref_i = r;
        @(posedge clk);
        if (r) begin
            hi_run = (hi_run < 1000) ? hi_run + 1 : 1000;
            lo_run = 0;
        end else begin
            lo_run = (lo_run < 1000) ? lo_run + 1 : 1000;
            hi_run = 0;
        end
        #1;
        check_all();
        if (master_en && main_en && comp_en && !main_pol && !comp_pol)
            chk("R4 overlap", {3'b000, main_o & comp_o}, 4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", {main_oe, main_o, comp_oe, comp_o}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0);
        chk("R1 after reset", {main_oe, main_o, comp_oe, comp_o}, 4'b0000);

        // Dead-time sweep: R2 R3 R4 R5
        master_en = 1; main_en = 1; comp_en = 1;
        for (int d = 0; d <= 6; d++) begin
            dead_time = 8'(d);
            repeat (10) cyc(1'b0);
            for (int p = 1; p <= d + 2; p++) begin
                for (int g = 1; g <= d + 2; g++) begin
                    repeat (p) cyc(1'b1);
                    repeat (g) cyc(1'b0);
                end
            end
        end
        repeat (10) cyc(1'b0);

        // Configuration sweep: R6..R12
        dead_time = 8'd2;
        for (int c = 0; c < 512; c++) begin
            main_en   = c[0];
            comp_en   = c[1];
            main_pol  = c[2];
            comp_pol  = c[3];
            idle_main = c[4];
            idle_comp = c[5];
            master_en = c[6];
            off_run   = c[7];
            off_idle  = c[8];
            repeat (4) cyc(1'b1);
            repeat (5) cyc(1'b0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule